// File: doc/BRIEF.md
# Legacy Memory Region Attribute Tracker

The tracker keeps two 32-bit attribute words that together describe how thirteen legacy firmware and option-ROM address windows are to be handled. When either word is written, it decodes the old and new words and sends one update event for each window whose 2-bit access state has changed. Each event carries the window's first and last byte address and its new state. A downstream memory-map agent consumes these events on a valid/ready output. Applying them to a map is left to that agent.

After reset the tracker reports the display window 0xA0000 to 0xBFFFF as MMIO. It then reports all thirteen windows, whether or not they changed, using the reset words. Events leave in ascending window order, at most one per cycle. A write that arrives while a scan is running is parked in a single pending slot and handled as soon as that scan ends.

The controller has three named states. RESET enters LEGACY. LEGACY moves to SCAN when the display event is accepted. SCAN moves to IDLE after window 12 if no write is waiting. SCAN restarts at window 0 after window 12 if a write is waiting. IDLE moves to SCAN when a write is taken.

Top module: `lmr_attr_tracker`

## Requirements
- R1: The two words form a 64-bit vector, with the word written using `wr_sel`=1 in bits 63:32 and the word written using `wr_sel`=0 in bits 31:0. Window i (0 to 12) takes its state from the 2-bit field at bit (i+3)*4. The state codes are 0 = MMIO, 1 = read-only, 2 = write-only and 3 = read-write.
- R2: Window 0 spans 0xF0000 to 0xFFFFF. Window k (1 to 12) spans 0xC0000+(k-1)*0x4000 to that start plus 0x3FFF. `evt_start` gives the first byte address and `evt_end` gives the last.
- R3: After reset, the first event is the display window 0xA0000 to 0xBFFFF with state 0. Thirteen events follow for windows 0 to 12 in order, decoded from the reset words 0x00000003 (low) and 0x00000000 (high). During reset, `busy` and `evt_valid` are 1.
- R4: A write produces events only for windows whose decoded state differs from the state before that write. The events go out in ascending window order.
- R5: A write that changes no window's state produces no event. `busy` still returns to 0 once the scan is over.
- R6: While `evt_valid` is 1 and `evt_ready` is 0, the event fields hold steady and the scan does not move on.
- R7: A write taken during a scan is held and processed after that scan. Its comparison uses the words committed at the moment its own processing starts. Its events follow the earlier scan's events with no idle gap.
- R8: While the pending slot is full, `wr_ready` is 0. A write is taken only when `wr_valid` and `wr_ready` are both 1.
- R9: `busy` is 1 from a taken write or reset until the final event of that scan is accepted. No event is offered while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Attribute word write request |
| wr_ready | output | 1 | Write can be taken (pending slot free) |
| wr_sel | input | 1 | 0 = low word, 1 = high word |
| wr_data | input | 32 | New attribute word |
| evt_valid | output | 1 | Update event offered |
| evt_ready | input | 1 | Consumer accepts the event |
| evt_start | output | 20 | First byte address of the window |
| evt_end | output | 20 | Last byte address of the window |
| evt_state | output | 2 | New access state code |
| busy | output | 1 | A scan is running or a write is waiting |

## Verification
The embedded properties assume that the consumer and the writer obey the handshakes. `wr_data` and `wr_sel` are meaningful only while `wr_valid` is 1. The bench never raises `wr_valid` while `wr_ready` is 0. The bench drives all inputs on the falling edge, so every request and every stall is a clean whole-cycle level. It creates stalls by dropping `evt_ready` while an event is on offer, and it queues a second write only while the first scan is stalled. That keeps the pending slot and the hold properties inside the assumed protocol.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
    localparam int LMR_REGIONS = 13;
    localparam int LMR_IDX_W   = $clog2(LMR_REGIONS);
    localparam int LMR_AW      = 20;
    localparam int LMR_DW      = 32;
    localparam int LMR_VEC_W   = 2 * LMR_DW;
    localparam int LMR_SLICE   = 14;

    localparam logic [LMR_AW-1:0] TOP_FIRST = 20'hF0000;
    localparam logic [LMR_AW-1:0] TOP_LAST  = 20'hFFFFF;
    localparam logic [LMR_AW-1:0] ROM_BASE  = 20'hC0000;
    localparam logic [LMR_AW-1:0] VID_FIRST = 20'hA0000;
    localparam logic [LMR_AW-1:0] VID_LAST  = 20'hBFFFF;

    typedef enum logic [1:0] {
        ST_MMIO = 2'd0,
        ST_RO   = 2'd1,
        ST_WO   = 2'd2,
        ST_RW   = 2'd3
    } attr_e;

    typedef enum logic [1:0] {
        FS_IDLE   = 2'd0,
        FS_LEGACY = 2'd1,
        FS_SCAN   = 2'd2
    } fsm_e;
endpackage

// File: rtl/lmr_decode.sv
module lmr_decode
    import lmr_pkg::*;
(
    input  logic [LMR_VEC_W-1:0]         vec,
    output logic [LMR_REGIONS-1:0][1:0]  st
);
    for (genvar i = 0; i < LMR_REGIONS; i++) begin : g_field
        assign st[i] = 2'(vec >> ((i + 3) * 4));
    end
endmodule

// File: rtl/lmr_window.sv
module lmr_window
    import lmr_pkg::*;
(
    input  logic [LMR_IDX_W-1:0] idx,
    input  logic                 legacy,
    output logic [LMR_AW-1:0]    w_lo,
    output logic [LMR_AW-1:0]    w_hi
);
    localparam logic [LMR_AW-1:0] SLICE_SPAN = LMR_AW'((1 << LMR_SLICE) - 1);

    logic [LMR_AW-1:0] rom_lo;
    assign rom_lo = ROM_BASE + (LMR_AW'(idx - LMR_IDX_W'(1)) << LMR_SLICE);

    always_comb begin
        if (legacy) begin
            w_lo = VID_FIRST;
            w_hi = VID_LAST;
        end else if (idx == '0) begin
            w_lo = TOP_FIRST;
            w_hi = TOP_LAST;
        end else begin
            w_lo = rom_lo;
            w_hi = rom_lo + SLICE_SPAN;
        end
    end
endmodule

// File: rtl/lmr_attr_tracker.sv
module lmr_attr_tracker
    import lmr_pkg::*;
#(
    parameter logic [LMR_DW-1:0] RESET_LO = 32'h0000_0003,
    parameter logic [LMR_DW-1:0] RESET_HI = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic              wr_sel,
    input  logic [LMR_DW-1:0] wr_data,
    output logic              evt_valid,
    input  logic              evt_ready,
    output logic [LMR_AW-1:0] evt_start,
    output logic [LMR_AW-1:0] evt_end,
    output logic [1:0]        evt_state,
    output logic              busy
);
    localparam logic [LMR_IDX_W-1:0] LAST_IDX = LMR_IDX_W'(LMR_REGIONS - 1);

    fsm_e                       fsm, fsm_nx;
    logic [LMR_IDX_W-1:0]       idx, idx_nx;
    logic [LMR_DW-1:0]          cur_lo, cur_hi, pend_data;
    logic                       pend_sel, pend_full, force_all;
    logic [LMR_REGIONS-1:0][1:0] old_st, new_st;

    logic              hit, last, advance, scan_end;
    logic              take_pend, take_dir, start_go, start_sel;
    logic [LMR_DW-1:0] start_data;

    lmr_decode u_dec (
        .vec ({cur_hi, cur_lo}),
        .st  (new_st)
    );

    lmr_window u_win (
        .idx    (idx),
        .legacy (fsm == FS_LEGACY),
        .w_lo   (evt_start),
        .w_hi   (evt_end)
    );

    assign hit        = force_all || (old_st[idx] != new_st[idx]);
    assign last       = (idx == LAST_IDX);
    assign advance    = (fsm == FS_SCAN) && (!hit || evt_ready);
    assign scan_end   = (fsm == FS_IDLE) || (advance && last);
    assign take_pend  = scan_end && pend_full;
    assign take_dir   = scan_end && !pend_full && wr_valid;
    assign start_go   = take_pend || take_dir;
    assign start_sel  = pend_full ? pend_sel  : wr_sel;
    assign start_data = pend_full ? pend_data : wr_data;
    assign wr_ready   = !pend_full;

    // next-state logic
    always_comb begin
        fsm_nx = fsm;
        idx_nx = idx;
        unique case (fsm)
            FS_IDLE: begin
                if (start_go) begin
                    fsm_nx = FS_SCAN;
                    idx_nx = '0;
                end
            end
            FS_LEGACY: begin
                if (evt_ready) begin
                    fsm_nx = FS_SCAN;
                    idx_nx = '0;
                end
            end
            FS_SCAN: begin
                if (advance) begin
                    if (last) begin
                        fsm_nx = start_go ? FS_SCAN : FS_IDLE;
                        idx_nx = '0;
                    end else begin
                        idx_nx = idx + LMR_IDX_W'(1);
                    end
                end
            end
            default: begin
                fsm_nx = FS_IDLE;
                idx_nx = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm <= FS_LEGACY;
            idx <= '0;
        end else begin
            fsm <= fsm_nx;
            idx <= idx_nx;
        end
    end

    // attribute words, snapshot and pending slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_lo    <= RESET_LO;
            cur_hi    <= RESET_HI;
            old_st    <= '0;
            force_all <= 1'b1;
            pend_full <= 1'b0;
            pend_sel  <= 1'b0;
            pend_data <= '0;
        end else begin
            if (start_go) begin
                old_st    <= new_st;
                force_all <= 1'b0;
                if (start_sel) cur_hi <= start_data;
                else           cur_lo <= start_data;
            end
            if (take_pend) begin
                pend_full <= 1'b0;
            end else if (wr_valid && wr_ready && !take_dir) begin
                pend_full <= 1'b1;
                pend_sel  <= wr_sel;
                pend_data <= wr_data;
            end
        end
    end

    // outputs
    always_comb begin
        evt_valid = 1'b0;
        evt_state = new_st[idx];
        unique case (fsm)
            FS_IDLE:   evt_valid = 1'b0;
            FS_LEGACY: begin
                evt_valid = 1'b1;
                evt_state = ST_MMIO;
            end
            FS_SCAN:   evt_valid = hit;
            default:   evt_valid = 1'b0;
        endcase
        busy = (fsm != FS_IDLE) || pend_full;
    end

    AST_WINDOW_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_end > evt_start)); // R2
    AST_LEGACY_TO_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm == FS_LEGACY) && evt_ready |=> (fsm == FS_SCAN) && (idx == '0) && force_all); // R3
    AST_IDX_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !last |=> (idx == $past(idx) + LMR_IDX_W'(1))); // R4
    AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && !evt_ready |=> evt_valid && $stable(evt_start) && $stable(evt_state) && $stable(idx)); // R6
    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        pend_full && !take_pend |=> pend_full && $stable(pend_data) && $stable(pend_sel)); // R7
    AST_EVT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> busy); // R9
endmodule

// File: tb/lmr_attr_tracker_tb.sv
`timescale 1ns/1ps
module lmr_attr_tracker_tb;
    import lmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n, wr_valid, wr_sel, evt_ready;
    logic [31:0] wr_data;
    logic        wr_ready, evt_valid, busy;
    logic [19:0] evt_start, evt_end;
    logic [1:0]  evt_state;

    lmr_attr_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_sel(wr_sel), .wr_data(wr_data), .evt_valid(evt_valid),
        .evt_ready(evt_ready), .evt_start(evt_start), .evt_end(evt_end),
        .evt_state(evt_state), .busy(busy)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_lo, m_hi;
    logic [19:0] e_lo [0:63];
    logic [19:0] e_hi [0:63];
    logic [1:0]  e_st [0:63];
    int e_n = 0;

    // {sel, data, expected event count}
    localparam logic [36:0] TBL [7] = '{
        {1'b0, 32'h0000_3000, 4'd1},
        {1'b1, 32'h0000_0001, 4'd1},
        {1'b0, 32'h0000_3000, 4'd0},
        {1'b0, 32'hFFFF_FFFF, 4'd4},
        {1'b1, 32'h1111_1111, 4'd7},
        {1'b1, 32'h2222_2222, 4'd8},
        {1'b0, 32'h0000_0000, 4'd5}
    };

    function automatic logic [1:0] mdec(int i);
        logic [63:0] v = {m_hi, m_lo};
        return 2'((v >> ((i + 3) * 4)) & 64'd3);
    endfunction

    function automatic logic [19:0] mfirst(int i);
        return (i == 0) ? 20'hF0000 : 20'(32'hC0000 + (i - 1) * 16384);
    endfunction

    function automatic logic [19:0] mlast(int i);
        return (i == 0) ? 20'hFFFFF : 20'(32'hC0000 + (i - 1) * 16384 + 16383);
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push_evt(logic [19:0] lo, logic [19:0] hi, logic [1:0] st);
        e_lo[e_n] = lo; e_hi[e_n] = hi; e_st[e_n] = st; e_n++;
    endtask

    task automatic model_write(logic sel, logic [31:0] data);
        logic [1:0] o [13];
        for (int i = 0; i < 13; i++) o[i] = mdec(i);
        if (sel) m_hi = data; else m_lo = data;
        for (int i = 0; i < 13; i++)
            if (mdec(i) != o[i]) push_evt(mfirst(i), mlast(i), mdec(i));
    endtask

    task automatic collect(string tag);
        int k = 0;
        for (int n = 0; n < 400; n++) begin
            if (!busy) break;
            if (evt_valid) begin
                if (k < e_n) begin
                    chk(evt_start == e_lo[k], {tag, " start (R2)"}, evt_start, e_lo[k]);
                    chk(evt_end == e_hi[k], {tag, " end (R2)"}, evt_end, e_hi[k]);
                    chk(evt_state == e_st[k], {tag, " state (R1)"}, evt_state, e_st[k]);
                end else begin
                    chk(1'b0, {tag, " extra event (R4)"}, evt_start, 0);
                end
                k++;
            end
            @(negedge clk);
        end
        chk(k == e_n, {tag, " event count"}, k, e_n);
        chk(!busy && !evt_valid, {tag, " idle after scan (R9)"}, {busy, evt_valid}, 0);
        e_n = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_valid = 1'b0; wr_sel = 1'b0; wr_data = '0; evt_ready = 1'b1;
        m_lo = 32'h3; m_hi = 32'h0;
        repeat (3) @(negedge clk);
        chk(busy && evt_valid && wr_ready, "R3 reset outputs", {busy, evt_valid, wr_ready}, 3'b111);
        chk(evt_start == 20'hA0000 && evt_state == 2'd0, "R3 display event in reset",
            {evt_start, evt_state}, {20'hA0000, 2'd0});
        rst_n = 1'b1;
        push_evt(20'hA0000, 20'hBFFFF, 2'd0);
        for (int i = 0; i < 13; i++) push_evt(mfirst(i), mlast(i), mdec(i));
        collect("R3 reset refresh");

        // table walk: R1 R4 R5
        for (int v = 0; v < 7; v++) begin
            model_write(TBL[v][36], TBL[v][35:4]);
            chk(e_n == int'(TBL[v][3:0]), "R4 model count vs table", e_n, TBL[v][3:0]);
            wr_sel = TBL[v][36]; wr_data = TBL[v][35:4]; wr_valid = 1'b1;
            @(negedge clk);
            wr_valid = 1'b0;
            chk(busy, "R9 busy after taken write", busy, 1);
            collect(TBL[v][3:0] == 0 ? "R5 no-change write" : "R4 changed write");
        end

        // stall and pending write: R6 R7 R8
        evt_ready = 1'b0;
        model_write(1'b0, 32'h0000_3330);
        model_write(1'b1, 32'h0000_0000);
        wr_sel = 1'b0; wr_data = 32'h0000_3330; wr_valid = 1'b1;
        @(negedge clk);
        wr_sel = 1'b1; wr_data = 32'h0000_0000;
        @(negedge clk);
        wr_valid = 1'b0;
        chk(!wr_ready, "R8 slot full blocks writes", wr_ready, 0);
        for (int s = 0; s < 3; s++) begin
            chk(evt_valid && evt_start == 20'hF0000 && evt_state == 2'd3, "R6 stalled event held",
                {evt_valid, evt_start, evt_state}, {1'b1, 20'hF0000, 2'd3});
            @(negedge clk);
        end
        evt_ready = 1'b1;
        collect("R7 queued write after scan");
        chk(wr_ready, "R8 slot free again", wr_ready, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule